// File: doc/BRIEF.md
# One-Wire ROM Search Triplet Unit

This block carries out a single decision step of the one-wire ROM search. A search controller pulses `start_i` together with a preferred branch `dir_i`. The unit then runs up to three bit slots on a touch-bit slot engine:

- a read slot that returns the device bit;
- a second read slot that returns its complement;
- a write slot that carries the branch actually chosen.

It then reports a packed 3-bit status with a one-cycle `done_o` pulse.

When every device answers 1 in both read slots, no device is driving the bus. The unit reports the error status and skips the write slot, so that the controller can restart the search. The full 64-bit loop, discrepancy bookkeeping and bus reset are left to the controller.

The slot port is a request/done handshake that the slot engine can stall as long as it likes:

- The unit raises `slot_req_o` with `slot_wbit_o` and holds both steady until the engine returns `slot_done_i`.
- A slot completes in the cycle where `slot_req_o` and `slot_done_i` are both high. `slot_rbit_i` is sampled in that same cycle.
- If `slot_req_o` is still high in the next cycle, that is a new slot.
- A read slot is a slot whose write bit is 1.

Top module: `owsrch_triplet`

## Requirements
- R1: After reset, `slot_req_o` is 0, `done_o` is 0 and `status_o` is 0.
- R2: A `start_i` accepted while idle runs a first slot with write bit 1 and a second slot with write bit 1. The results of these slots are id and cmp.
- R3: When id=1 and cmp=1, `status_o` is 3 (binary 011). Only two slots are run, and no further slot follows.
- R4: When id=0 and cmp=0, the branch taken is the `dir_i` value sampled at the accepted start. The third slot writes that branch, and the status is 4 for branch 1 or 0 for branch 0.
- R5: When exactly one of id and cmp is 1, the branch taken equals id. The third slot writes it, and the status is 5 (id=1) or 2 (cmp=1).
- R6: The status fields are: bit 0 is id, bit 1 is cmp, and bit 2 is the branch taken (0 in the error case).
- R7: `start_i` has no effect while a triplet is in progress. `dir_i` changes after the accepted start cycle do not alter the branch taken.
- R8: `done_o` is high for exactly one cycle per triplet. `status_o` changes only in the cycle `done_o` rises and holds its value otherwise. `slot_req_o` is low while `done_o` is high.
- R9: Once raised, `slot_req_o` stays high and `slot_wbit_o` stays unchanged until the slot's `slot_done_i` cycle.
- R10: `done_o` rises in the cycle right after the last slot's `slot_done_i` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a triplet (taken only when idle) |
| dir_i | input | 1 | Preferred branch when devices disagree |
| slot_req_o | output | 1 | Slot request to the slot engine |
| slot_wbit_o | output | 1 | Bit to drive in the requested slot |
| slot_rbit_i | input | 1 | Bus level sampled in the slot |
| slot_done_i | input | 1 | Slot engine reports the slot complete |
| status_o | output | 3 | Packed result {branch, cmp, id} |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The checker watches several properties on every cycle:

- the slot handshake holding (R9);
- the done pulse width, and status holding between pulses (R8);
- the status encodings that cannot occur, such as a single 1 bit disagreeing with bit 2 (R6).

Only the directed scenarios show the rest, because those properties need the full slot history that the ports alone do not carry at one instant. These are the order and write values of the slots, the missing third slot on error, the done latency after the last slot, and that a late `start_i` or `dir_i` change is ignored. They cover every id/cmp/dir combination under several slot engine stall lengths.

// File: rtl/owt_pkg.sv
`timescale 1ns/1ps
package owt_pkg;
  localparam int STAT_W = 3;
  localparam logic [STAT_W-1:0] STAT_ERR = 3'b011;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RD_ID  = 2'd1,
    ST_RD_CMP = 2'd2,
    ST_WR_DIR = 2'd3
  } owt_state_e;
endpackage

// File: rtl/owt_decide.sv
`timescale 1ns/1ps
module owt_decide
  import owt_pkg::*;
(
  input  logic              id_bit_i,
  input  logic              cmp_bit_i,
  input  logic              pref_i,
  output logic              err_o,
  output logic              branch_o,
  output logic [STAT_W-1:0] status_o
);
  always_comb begin
    err_o = id_bit_i & cmp_bit_i;
    if (id_bit_i ^ cmp_bit_i) branch_o = id_bit_i;
    else if (err_o)           branch_o = 1'b0;
    else                      branch_o = pref_i;
    status_o = {branch_o, cmp_bit_i, id_bit_i};
  end
endmodule

// File: rtl/owt_fsm.sv
`timescale 1ns/1ps
module owt_fsm
  import owt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       slot_done_i,
  input  logic       err_i,
  output owt_state_e state_o,
  output logic       accept_o,
  output logic       cap_id_o,
  output logic       cap_cmp_o,
  output logic       finish_o
);
  owt_state_e nxt;

  always_comb begin
    accept_o  = (state_o == ST_IDLE) && start_i;
    cap_id_o  = (state_o == ST_RD_ID) && slot_done_i;
    cap_cmp_o = (state_o == ST_RD_CMP) && slot_done_i;
    finish_o  = (cap_cmp_o && err_i) || ((state_o == ST_WR_DIR) && slot_done_i);
    nxt = state_o;
    unique case (state_o)
      ST_IDLE:   if (accept_o) nxt = ST_RD_ID;
      ST_RD_ID:  if (cap_id_o) nxt = ST_RD_CMP;
      ST_RD_CMP: if (cap_cmp_o) nxt = err_i ? ST_IDLE : ST_WR_DIR;
      ST_WR_DIR: if (slot_done_i) nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_o <= ST_IDLE;
    else        state_o <= nxt;
  end
endmodule

// File: rtl/owt_result.sv
`timescale 1ns/1ps
module owt_result
  import owt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [STAT_W-1:0] status_d_i,
  output logic [STAT_W-1:0] status_o,
  output logic              done_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_o <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= load_i;
      if (load_i) status_o <= status_d_i;
    end
  end
endmodule

// File: rtl/owsrch_triplet.sv
`timescale 1ns/1ps
module owsrch_triplet
  import owt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              dir_i,
  output logic              slot_req_o,
  output logic              slot_wbit_o,
  input  logic              slot_rbit_i,
  input  logic              slot_done_i,
  output logic [STAT_W-1:0] status_o,
  output logic              done_o
);
  owt_state_e        state;
  logic              accept, cap_id, cap_cmp, finish;
  logic              id_q, cmp_q, pref_q, cmp_src;
  logic              err, branch;
  logic [STAT_W-1:0] status_d;

  owt_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .slot_done_i (slot_done_i),
    .err_i       (err),
    .state_o     (state),
    .accept_o    (accept),
    .cap_id_o    (cap_id),
    .cap_cmp_o   (cap_cmp),
    .finish_o    (finish)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      id_q   <= 1'b0;
      cmp_q  <= 1'b0;
      pref_q <= 1'b0;
    end else begin
      if (accept)  pref_q <= dir_i;
      if (cap_id)  id_q   <= slot_rbit_i;
      if (cap_cmp) cmp_q  <= slot_rbit_i;
    end
  end

  // the complement bit is used live in its own slot, registered afterwards
  assign cmp_src = (state == ST_RD_CMP) ? slot_rbit_i : cmp_q;

  owt_decide u_decide (
    .id_bit_i  (id_q),
    .cmp_bit_i (cmp_src),
    .pref_i    (pref_q),
    .err_o     (err),
    .branch_o  (branch),
    .status_o  (status_d)
  );

  owt_result u_result (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (finish),
    .status_d_i (status_d),
    .status_o   (status_o),
    .done_o     (done_o)
  );

  assign slot_req_o  = (state != ST_IDLE);
  assign slot_wbit_o = (state == ST_WR_DIR) ? branch : 1'b1;
endmodule

// File: rtl/owt_chk.sv
`timescale 1ns/1ps
module owt_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       slot_req_o,
  input logic       slot_wbit_o,
  input logic       slot_done_i,
  input logic [2:0] status_o,
  input logic       done_o
);
  a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_req_o && !slot_done_i) |=> (slot_req_o && $stable(slot_wbit_o)));

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r8_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(status_o));

  a_r8_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !slot_req_o);

  a_r6_id_only: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && status_o[1:0] == 2'b01) |-> status_o[2]);

  a_r6_cmp_only: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && status_o[1:0] == 2'b10) |-> !status_o[2]);

  a_r3_err_code: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && status_o[1:0] == 2'b11) |-> !status_o[2]);
endmodule

bind owsrch_triplet owt_chk u_owt_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .slot_req_o  (slot_req_o),
  .slot_wbit_o (slot_wbit_o),
  .slot_done_i (slot_done_i),
  .status_o    (status_o),
  .done_o      (done_o)
);

// File: tb/test_owsrch_triplet.sv
`timescale 1ns/1ps
module test_owsrch_triplet;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, dir_i = 1'b0;
  logic slot_req_o, slot_wbit_o;
  logic slot_rbit_i = 1'b1, slot_done_i = 1'b0;
  logic [2:0] status_o;
  logic done_o;

  int nchk = 0, nfail = 0, cyc = 0;
  int idx = 0, base = 0, cnt = 0, lat = 0, last_done_cyc = 0;
  logic [2:0] resp = 3'b111;
  logic [2:0] wlog = 3'b000;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  owsrch_triplet i_owsrch_triplet (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .dir_i(dir_i),
    .slot_req_o(slot_req_o), .slot_wbit_o(slot_wbit_o),
    .slot_rbit_i(slot_rbit_i), .slot_done_i(slot_done_i),
    .status_o(status_o), .done_o(done_o));

  // slot engine model: stalls lat cycles per slot, answers from resp
  always @(negedge clk) begin
    if (!rst_n) begin
      slot_done_i <= 1'b0;
      cnt <= 0;
    end else if (slot_done_i) begin
      slot_done_i <= 1'b0;
      idx <= idx + 1;
      cnt <= 0;
    end else if (slot_req_o) begin
      if (cnt >= lat) begin
        slot_done_i <= 1'b1;
        last_done_cyc <= cyc;
        if (idx - base < 3) begin
          slot_rbit_i <= resp[idx - base];
          wlog[idx - base] <= slot_wbit_o;
        end else slot_rbit_i <= 1'b1;
      end else cnt <= cnt + 1;
    end
  end

  task automatic check_eq(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic run_case(input logic id, input logic cmp, input logic dir,
                          input int l, input bit poke);
    logic err, br;
    logic [2:0] exp_st;
    int t;
    int slots_before_quiet;
    err = id & cmp;
    br  = err ? 1'b0 : ((id | cmp) ? id : dir);
    exp_st = {br, cmp, id};
    base = idx;
    resp = {1'b1, cmp, id};
    lat = l;
    start_i = 1'b1; dir_i = dir;
    step();
    start_i = 1'b0; dir_i = ~dir;
    t = 0;
    while (!done_o && t < 500) begin
      start_i = (poke && t == 1);
      step();
      t++;
    end
    start_i = 1'b0;
    check_eq("R8 done seen", done_o, 1);
    check_eq(err ? "R3 error status" : ((id | cmp) ? "R5 single-bit status" : "R4 disagree status"),
             status_o, exp_st);
    check_eq("R6 bit0 id", status_o[0], id);
    check_eq(err ? "R3 slot count" : "R2 slot count", idx - base, err ? 2 : 3);
    check_eq("R2 first slot reads", wlog[0], 1);
    check_eq("R2 second slot reads", wlog[1], 1);
    if (!err) check_eq(id | cmp ? "R5 branch written" : "R4 branch written", wlog[2], br);
    check_eq("R10 done latency", cyc - last_done_cyc, 1);
    step();
    check_eq("R8 done one cycle", done_o, 0);
    check_eq("R8 status held", status_o, exp_st);
    slots_before_quiet = idx;
    for (int k = 0; k < 6; k++) begin
      step();
      if (slot_req_o) break;
    end
    check_eq(poke ? "R7 late start ignored" : (err ? "R3 no extra slot" : "R8 idle after done"),
             slot_req_o, 0);
    check_eq("R7 no extra slots", idx, slots_before_quiet);
  endtask

  task automatic test_reset();
    check_eq("R1 slot_req reset", slot_req_o, 0);
    check_eq("R1 done reset", done_o, 0);
    check_eq("R1 status reset", status_o, 0);
  endtask

  initial begin
    #(20 * 200000);
    nfail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nchk + 1 - nfail, nchk + 1);
    $finish;
  end

  initial begin
    repeat (3) step();
    test_reset();
    rst_n = 1'b1;
    step();
    test_reset();
    run_case(1'b0, 1'b0, 1'b1, 0, 1'b0);
    run_case(1'b0, 1'b0, 1'b0, 2, 1'b0);
    run_case(1'b1, 1'b0, 1'b0, 1, 1'b0);
    run_case(1'b1, 1'b0, 1'b1, 3, 1'b0);
    run_case(1'b0, 1'b1, 1'b1, 0, 1'b0);
    run_case(1'b0, 1'b1, 1'b0, 4, 1'b0);
    run_case(1'b1, 1'b1, 1'b0, 0, 1'b0);
    run_case(1'b1, 1'b1, 1'b1, 5, 1'b0);
    run_case(1'b0, 1'b0, 1'b1, 3, 1'b1);
    run_case(1'b0, 1'b0, 1'b0, 2, 1'b1);
    run_case(1'b1, 1'b1, 1'b0, 2, 1'b1);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule